// File: doc/BRIEF.md
# ADC Input Channel Scan Sequencer

This block decides, for every conversion of a successive-approximation converter, which analog input feeds each of four sample-and-hold channels. It drives a positive input code and a negative input code per channel and tells the converter which channel is being converted. One conversion step moves forward on each `advance` strobe. The converter pulses that strobe once it has finished a conversion.

Channel 0 can take its positive input from a fixed select or from a scan. The scan walks a 32-bit mask of enabled inputs upward and moves on one input per completed sample. The block can also switch between two sets of input selects (set A and set B) on successive samples. Per sample it converts one, two or four channels, in channel order. A high-resolution mode limits every sample to channel 0. Analog multiplexing and the converter itself lie outside this block.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, and in every cycle after `enable` was low on a clock edge, `conv_ch` is 0, `sample_b` is 0, and the scan position is back at its start, so the next scanned input is the lowest set mask bit.
- R2: With scan and alternation off, channel 0's positive code equals `ch0_pos_a`. `ch0_neg_a`=0 selects the low reference (`ch_neg_ref[0]`=1, negative code 0). `ch0_neg_a`=1 selects input 1 (`ch_neg_ref[0]`=0, negative code 1).
- R3: With `scan_en`=1, channel 0's positive code during a set-A sample is the lowest set mask bit at or above the scan position. The position moves past that input when the sample completes, and `ch0_pos_a` is ignored.
- R4: After the highest set mask bit, the scan wraps to the lowest set mask bit.
- R5: With `scan_en`=1 and an all-zero mask, channel 0's positive code is 0.
- R6: With `alt_en`=1, samples alternate between set A (`sample_b`=0) and set B (`sample_b`=1), starting with A. During set B, channel 0 uses `ch0_pos_b` and `ch0_neg_b`, and channels 1 to 3 use `grp_pos_b` and `grp_neg_b`. With `alt_en`=0, every sample uses set A.
- R7: With scan and alternation both on, set-B samples take channel 0's positive code from `ch0_pos_b`, and the scan position moves only when a set-A sample completes.
- R8: `chan_cnt` 00 converts channel 0 only, 01 converts channels 0 and 1, and 1x converts channels 0 to 3. `conv_ch` goes up by one on each `advance`. `conv_last` is 1 on the last channel of the sample, and the next `advance` returns `conv_ch` to 0 and completes the sample.
- R9: With `hi_res`=1, every sample converts channel 0 only, whatever `chan_cnt` holds: `conv_last` is 1 and `conv_ch` stays 0.
- R10: For channel k in 1..3, the group select value 0 picks input k-1 and the value 1 picks input k+2. The group negative field picks the low reference for 0x, input k+5 for 10 and input k+8 for 11. A negative code is 0 whenever its reference flag is set.
- R11: While `enable` is low, `advance` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module on; low holds the sequence at its start |
| scan_en | input | 1 | Channel 0 positive input taken from the scan |
| alt_en | input | 1 | Alternate set A and set B on successive samples |
| hi_res | input | 1 | High-resolution mode, channel 0 only |
| chan_cnt | input | 2 | Channels converted per sample |
| ch0_pos_a | input | 5 | Channel 0 positive select, set A |
| ch0_neg_a | input | 1 | Channel 0 negative select, set A |
| ch0_pos_b | input | 5 | Channel 0 positive select, set B |
| ch0_neg_b | input | 1 | Channel 0 negative select, set B |
| grp_pos_a | input | 1 | Channels 1-3 positive group select, set A |
| grp_neg_a | input | 2 | Channels 1-3 negative group select, set A |
| grp_pos_b | input | 1 | Channels 1-3 positive group select, set B |
| grp_neg_b | input | 2 | Channels 1-3 negative group select, set B |
| scan_mask | input | 32 | Inputs taking part in the scan |
| advance | input | 1 | One conversion finished |
| ch_pos | output | 20 | Positive input codes, channel k at bits 5k+4:5k |
| ch_neg | output | 20 | Negative input codes, same packing |
| ch_neg_ref | output | 4 | Per channel: negative input is the low reference |
| conv_ch | output | 2 | Channel now handed to the converter |
| conv_last | output | 1 | Current channel is the last of the sample |
| sample_b | output | 1 | Current sample uses select set B |

## Verification
The bench checks the scan across its wrap from input 31 back to the lowest set bit. A sequencer that stopped at the top, or restarted from input 0, would output the wrong code there. It uses a two-channel sample to confirm that the scan moves once per sample and not once per conversion, and it uses combined scan and alternation to catch a design that moves the scan on set-B samples too. It also drives high resolution with `chan_cnt`=11, pulses `advance` while the block is disabled, and uses an empty mask. Each of these exposes a sequencer that counts channels it should skip, or leaves state behind across a disable.

// File: rtl/adc_scan_seq_pkg.sv
package adc_scan_seq_pkg;

    localparam int NUM_CH = 4;
    localparam int CIDX_W = $clog2(NUM_CH);

    // Index of the last channel converted in one sample.
    function automatic logic [CIDX_W-1:0] last_index(input logic hi_res,
                                                     input logic [1:0] cnt);
        logic [CIDX_W-1:0] r;
        if (hi_res)          r = '0;
        else if (cnt[1])     r = CIDX_W'(NUM_CH - 1);
        else if (cnt[0])     r = CIDX_W'(1);
        else                 r = '0;
        return r;
    endfunction

endpackage

// File: rtl/adc_scan_pick.sv
// Finds the lowest set mask bit at or above a start index, wrapping.
module adc_scan_pick #(
    parameter int N_IN  = 32,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  mask,
    input  logic [SEL_W-1:0] start,
    output logic [SEL_W-1:0] pick
);
    logic [2*N_IN-1:0] dbl;
    logic [N_IN-1:0]   rot;
    logic [SEL_W-1:0]  offset;

    always_comb begin
        dbl    = {mask, mask};
        rot    = N_IN'(dbl >> start);
        offset = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (rot[i]) offset = SEL_W'(i);
        end
        pick = (mask == '0) ? '0 : SEL_W'(start + offset);
    end
endmodule

// File: rtl/adc_chan_select.sv
// Produces the per-channel input codes for the current sample.
module adc_chan_select
    import adc_scan_seq_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic                    phase_b,
    input  logic                    scan_en,
    input  logic [SEL_W-1:0]        scan_code,
    input  logic [SEL_W-1:0]        ch0_pos_a,
    input  logic                    ch0_neg_a,
    input  logic [SEL_W-1:0]        ch0_pos_b,
    input  logic                    ch0_neg_b,
    input  logic                    grp_pos_a,
    input  logic [1:0]              grp_neg_a,
    input  logic                    grp_pos_b,
    input  logic [1:0]              grp_neg_b,
    output logic [NUM_CH*SEL_W-1:0] ch_pos,
    output logic [NUM_CH*SEL_W-1:0] ch_neg,
    output logic [NUM_CH-1:0]       ch_neg_ref
);
    logic       ch0_neg_sel;
    logic       grp_pos;
    logic [1:0] grp_neg;

    always_comb begin
        ch0_neg_sel = phase_b ? ch0_neg_b : ch0_neg_a;
        grp_pos     = phase_b ? grp_pos_b : grp_pos_a;
        grp_neg     = phase_b ? grp_neg_b : grp_neg_a;
    end

    // Channel 0: scan replaces the set-A positive select only.
    always_comb begin
        if (phase_b)       ch_pos[SEL_W-1:0] = ch0_pos_b;
        else if (scan_en)  ch_pos[SEL_W-1:0] = scan_code;
        else               ch_pos[SEL_W-1:0] = ch0_pos_a;
        ch_neg_ref[0]     = ~ch0_neg_sel;
        ch_neg[SEL_W-1:0] = ch0_neg_sel ? SEL_W'(1) : '0;
    end

    for (genvar k = 1; k < NUM_CH; k++) begin : g_grp
        always_comb begin
            ch_pos[k*SEL_W +: SEL_W] = grp_pos ? SEL_W'(k + 2) : SEL_W'(k - 1);
            ch_neg_ref[k]            = ~grp_neg[1];
            if (!grp_neg[1])     ch_neg[k*SEL_W +: SEL_W] = '0;
            else if (grp_neg[0]) ch_neg[k*SEL_W +: SEL_W] = SEL_W'(k + 8);
            else                 ch_neg[k*SEL_W +: SEL_W] = SEL_W'(k + 5);
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_seq_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    scan_en,
    input  logic                    alt_en,
    input  logic                    hi_res,
    input  logic [1:0]              chan_cnt,
    input  logic [SEL_W-1:0]        ch0_pos_a,
    input  logic                    ch0_neg_a,
    input  logic [SEL_W-1:0]        ch0_pos_b,
    input  logic                    ch0_neg_b,
    input  logic                    grp_pos_a,
    input  logic [1:0]              grp_neg_a,
    input  logic                    grp_pos_b,
    input  logic [1:0]              grp_neg_b,
    input  logic [N_IN-1:0]         scan_mask,
    input  logic                    advance,
    output logic [NUM_CH*SEL_W-1:0] ch_pos,
    output logic [NUM_CH*SEL_W-1:0] ch_neg,
    output logic [NUM_CH-1:0]       ch_neg_ref,
    output logic [CIDX_W-1:0]       conv_ch,
    output logic                    conv_last,
    output logic                    sample_b
);
    typedef struct packed {
        logic [SEL_W-1:0]  scan_ptr;
        logic              phase_b;
        logic [CIDX_W-1:0] conv_idx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [SEL_W-1:0]  scan_code;
    logic [CIDX_W-1:0] last_idx;
    logic              at_last;

    adc_scan_pick #(.N_IN(N_IN), .SEL_W(SEL_W)) u_pick (
        .mask  (scan_mask),
        .start (st_q.scan_ptr),
        .pick  (scan_code)
    );

    adc_chan_select #(.SEL_W(SEL_W)) u_sel (
        .phase_b    (st_q.phase_b),
        .scan_en    (scan_en),
        .scan_code  (scan_code),
        .ch0_pos_a  (ch0_pos_a),
        .ch0_neg_a  (ch0_neg_a),
        .ch0_pos_b  (ch0_pos_b),
        .ch0_neg_b  (ch0_neg_b),
        .grp_pos_a  (grp_pos_a),
        .grp_neg_a  (grp_neg_a),
        .grp_pos_b  (grp_pos_b),
        .grp_neg_b  (grp_neg_b),
        .ch_pos     (ch_pos),
        .ch_neg     (ch_neg),
        .ch_neg_ref (ch_neg_ref)
    );

    always_comb begin
        last_idx = last_index(hi_res, chan_cnt);
        // A count lowered mid-sample ends the sample at the next strobe.
        at_last  = (st_q.conv_idx >= last_idx);
        st_d     = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (advance) begin
            if (at_last) begin
                st_d.conv_idx = '0;
                st_d.phase_b  = alt_en ? ~st_q.phase_b : 1'b0;
                if (scan_en && !st_q.phase_b)
                    st_d.scan_ptr = SEL_W'(scan_code + 1'b1);
            end else begin
                st_d.conv_idx = st_q.conv_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_ch   = st_q.conv_idx;
    assign conv_last = at_last;
    assign sample_b  = st_q.phase_b;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_scan_seq_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int SEL_W = $clog2(N_IN)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic                    scan_en,
    input logic                    alt_en,
    input logic                    hi_res,
    input logic [N_IN-1:0]         scan_mask,
    input logic                    advance,
    input logic [NUM_CH*SEL_W-1:0] ch_pos,
    input logic [CIDX_W-1:0]       conv_ch,
    input logic                    conv_last,
    input logic                    sample_b
);
    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (conv_ch == '0) && !sample_b);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !advance) |=> $stable(conv_ch) && $stable(sample_b));

    assert_alt_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && advance && conv_last && !alt_en) |=> !sample_b);

    assert_step_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && advance && !conv_last) |=> conv_ch == $past(conv_ch) + 1'b1);

    assert_hires_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_res |-> conv_last);

    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !sample_b && scan_mask == '0) |-> ch_pos[SEL_W-1:0] == '0);

    assert_scan_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !sample_b && scan_mask != '0) |-> scan_mask[ch_pos[SEL_W-1:0]]);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_IN(N_IN), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scan_en   (scan_en),
    .alt_en    (alt_en),
    .hi_res    (hi_res),
    .scan_mask (scan_mask),
    .advance   (advance),
    .ch_pos    (ch_pos),
    .conv_ch   (conv_ch),
    .conv_last (conv_last),
    .sample_b  (sample_b)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1, scan_en = 1'b0, alt_en = 1'b0, hi_res = 1'b0;
    logic [1:0]  chan_cnt = 2'b00;
    logic [4:0]  ch0_pos_a = '0, ch0_pos_b = '0;
    logic        ch0_neg_a = 1'b0, ch0_neg_b = 1'b0;
    logic        grp_pos_a = 1'b0, grp_pos_b = 1'b0;
    logic [1:0]  grp_neg_a = '0, grp_neg_b = '0;
    logic [31:0] scan_mask = '0;
    logic        advance = 1'b0;
    logic [19:0] ch_pos, ch_neg;
    logic [3:0]  ch_neg_ref;
    logic [1:0]  conv_ch;
    logic        conv_last, sample_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_scan_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scan_en(scan_en),
        .alt_en(alt_en), .hi_res(hi_res), .chan_cnt(chan_cnt),
        .ch0_pos_a(ch0_pos_a), .ch0_neg_a(ch0_neg_a),
        .ch0_pos_b(ch0_pos_b), .ch0_neg_b(ch0_neg_b),
        .grp_pos_a(grp_pos_a), .grp_neg_a(grp_neg_a),
        .grp_pos_b(grp_pos_b), .grp_neg_b(grp_neg_b),
        .scan_mask(scan_mask), .advance(advance),
        .ch_pos(ch_pos), .ch_neg(ch_neg), .ch_neg_ref(ch_neg_ref),
        .conv_ch(conv_ch), .conv_last(conv_last), .sample_b(sample_b)
    );

    typedef struct packed {
        logic [4:0]  pos_a;
        logic        neg_a;
        logic        grp;
        logic [1:0]  gneg;
        logic [19:0] e_pos;
        logic [3:0]  e_nref;
        logic [19:0] e_neg;
    } vec_t;

    // Static select decoding, scan and alternation off (R2, R10).
    localparam vec_t VECS [4] = '{
        '{5'd7,  1'b0, 1'b0, 2'b00, {5'd2, 5'd1, 5'd0, 5'd7},  4'b1111, 20'd0},
        '{5'd31, 1'b1, 1'b1, 2'b10, {5'd5, 5'd4, 5'd3, 5'd31}, 4'b0000, {5'd8, 5'd7, 5'd6, 5'd1}},
        '{5'd0,  1'b1, 1'b0, 2'b11, {5'd2, 5'd1, 5'd0, 5'd0},  4'b0000, {5'd11, 5'd10, 5'd9, 5'd1}},
        '{5'd18, 1'b0, 1'b1, 2'b01, {5'd5, 5'd4, 5'd3, 5'd18}, 4'b1111, 20'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) advance = 1'b1;
        @(negedge clk) advance = 1'b0;
        #1;
    endtask

    task automatic restart();
        @(negedge clk) enable = 1'b0;
        @(negedge clk) enable = 1'b1;
        #1;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 conv_ch", conv_ch, 0);
        chk("R1 sample_b", sample_b, 0);

        for (int i = 0; i < 4; i++) begin
            ch0_pos_a = VECS[i].pos_a; ch0_neg_a = VECS[i].neg_a;
            grp_pos_a = VECS[i].grp;   grp_neg_a = VECS[i].gneg;
            #1;
            chk("R2/R10 pos", ch_pos, VECS[i].e_pos);
            chk("R2/R10 nref", ch_neg_ref, VECS[i].e_nref);
            chk("R2/R10 neg", ch_neg, VECS[i].e_neg);
        end

        // R8 two channels, then four
        chan_cnt = 2'b01; #1;
        chk("R8 two start last", conv_last, 0);
        pulse(); chk("R8 two ch1", conv_ch, 1); chk("R8 two last", conv_last, 1);
        pulse(); chk("R8 two wrap", conv_ch, 0);
        chan_cnt = 2'b10;
        pulse(); pulse(); pulse();
        chk("R8 four ch3", conv_ch, 3); chk("R8 four last", conv_last, 1);
        pulse(); chk("R8 four wrap", conv_ch, 0);

        // R9 high resolution overrides the count
        chan_cnt = 2'b11; hi_res = 1'b1; #1;
        chk("R9 last", conv_last, 1);
        pulse(); chk("R9 stays ch0", conv_ch, 0);
        hi_res = 1'b0; chan_cnt = 2'b00;

        // R6 alternation
        ch0_pos_a = 5'd4; ch0_neg_a = 1'b0; ch0_pos_b = 5'd22; ch0_neg_b = 1'b1;
        grp_pos_b = 1'b1; grp_neg_b = 2'b11;
        alt_en = 1'b1; restart();
        chk("R6 first A", sample_b, 0);
        chk("R6 A pos", ch_pos[4:0], 4);
        pulse();
        chk("R6 then B", sample_b, 1);
        chk("R6 B pos", ch_pos[4:0], 22);
        chk("R6 B nref", ch_neg_ref, 4'b0000);
        chk("R6 B grp pos", ch_pos[19:5], {5'd5, 5'd4, 5'd3});
        pulse(); chk("R6 back to A", sample_b, 0);
        alt_en = 1'b0;
        pulse(); pulse();
        chk("R6 off stays A", sample_b, 0);

        // R3 / R4 scan with wrap, one step per sample
        scan_mask = (32'd1 << 3) | (32'd1 << 10) | (32'd1 << 31);
        ch0_pos_a = 5'd5; scan_en = 1'b1; restart();
        chk("R3 first", ch_pos[4:0], 3);
        chan_cnt = 2'b01;
        pulse(); chk("R3 held mid-sample", ch_pos[4:0], 3);
        pulse(); chk("R3 next", ch_pos[4:0], 10);
        chan_cnt = 2'b00;
        pulse(); chk("R3 top", ch_pos[4:0], 31);
        pulse(); chk("R4 wrap", ch_pos[4:0], 3);

        // R11 and R1: disabled strobes ignored, scan restarts
        pulse(); chk("R11 pre", ch_pos[4:0], 10);
        chan_cnt = 2'b01;
        @(negedge clk) enable = 1'b0;
        pulse(); pulse();
        chk("R11 ignored", conv_ch, 0);
        @(negedge clk) enable = 1'b1; #1;
        chk("R1 scan restart", ch_pos[4:0], 3);
        chan_cnt = 2'b00;

        // R5 empty mask
        scan_mask = '0; #1;
        chk("R5 zero mask", ch_pos[4:0], 0);

        // R7 scan with alternation
        scan_mask = (32'd1 << 2) | (32'd1 << 6);
        alt_en = 1'b1; ch0_pos_b = 5'd20; restart();
        chk("R7 A1", ch_pos[4:0], 2);
        pulse(); chk("R7 B1", ch_pos[4:0], 20);
        pulse(); chk("R7 A2", ch_pos[4:0], 6);
        pulse(); chk("R7 B2", ch_pos[4:0], 20);
        pulse(); chk("R7 A3 wrap", ch_pos[4:0], 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule